// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave serial port for a bank of sixteen 8-bit registers. A host reaches it over three wires: a chip enable, a shift clock and one data line whose direction the block controls. All pins are oversampled on a faster system clock. Each transaction opens with a rising chip enable. The block then shifts in an 8-bit header and moves data in 8-bit units. The low nibble of the header is the mode code and the high nibble is the start address. Every field travels least significant bit first.

Write mode stores each completed byte and steps the address. Read mode copies the addressed register into an output shifter and shifts it out one bit per shift-clock rise. Any other mode code makes the rest of the transaction inert. The top register (address 15) holds status and control bits with special rules: a carry-seen flag, a test bit, a reset bit, four plain storage bits and a write-fail flag. The timekeeping logic behind the port reads every register through a flat output bus and reports seconds carries through a one-cycle pulse input.

Top module: `serRegPort`

## Requirements
- R1: After reset all sixteen registers read zero and the data line is not driven (`dataOe` low).
- R2: With both enables high, a header whose low nibble is 3 (header bits 0..3 = 1,1,0,0) selects write mode. Each later byte, least significant bit first, is stored at the current address.
- R3: After every complete data byte in either mode the address steps by one, and address 15 is followed by address 0.
- R4: A mode nibble of 12 (header bits 0..3 = 0,0,1,1) selects read mode. `dataOe` then rises and bit 0 of the addressed register is on `dataOut` once the last header bit has been clocked. Each further shift-clock rise presents the next bit, and after bit 7 the rise presents bit 0 of the next register.
- R5: Any other mode code leaves every register unchanged and keeps `dataOe` low until the chip enable drops.
- R6: If the chip enable drops while a write byte is partly shifted, that partial byte is discarded, earlier complete bytes stay stored, and status bit 0 (write-fail) is set. A drop on a byte boundary does not set it.
- R7: The write-fail bit is cleared only by a host write of 0 to status bit 0. A host write of 1 to that bit never sets it.
- R8: While the chip enable is low, `dataOe` is low and status bits 7 (carry-seen), 6 (test) and 5 (reset) are forced to 0. Status bits 4..1 are plain storage.
- R9: A `carryPulse` while the chip enable is high sets status bit 7. Host writes never change that bit. A host write to the status register in the same cycle as the pulse keeps both effects.
- R10: In read mode each byte is copied from its register when the byte starts. A register change during the shifting of that byte does not alter the bits sent.
- R11: Access requires both chip-enable inputs high. With one of them low, no register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| ce0 | input | 1 | First chip-enable input |
| ce1 | input | 1 | Second chip-enable input |
| sclk | input | 1 | Host shift clock |
| dataIn | input | 1 | Level seen on the serial data line |
| carryPulse | input | 1 | One-cycle seconds-carry notice from the timekeeping logic |
| dataOut | output | 1 | Bit driven onto the serial data line in read mode |
| dataOe | output | 1 | Drive enable for the serial data line (low means high impedance) |
| regsOut | output | 128 | All registers, register n at bits 8n+7..8n |

## Verification
The status register has two update sources that can land in the same system-clock cycle: a host write strobe completing a byte at address 15, and a carry pulse from the timekeeping side. The bench times `carryPulse` to the exact cycle in which the eighth bit of a status write is committed. That cycle is the third system-clock edge after the shift-clock rise, counting two synchronizer stages and the edge detector. The bench then requires the status value to show both the written test and reset bits and the carry-seen bit. A second pulse arrives while a status byte is being shifted out in read mode. That byte must still show the flag clear, and a later pass over the same address after wrap-around must show it set.

// File: rtl/serRegPkg.sv
package serRegPkg;

  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] CODE_WR = 4'h3;
  localparam logic [MODE_W-1:0] CODE_RD = 4'hC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } portState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic shiftIn;    // capture one serial bit
    logic latchAddr;  // header complete: take start address
    logic incAddr;    // data unit complete: step address
    logic loadRd;     // copy a register into the output shifter
    logic shiftRd;    // present next output bit
    logic wrStrobe;   // commit a received byte
    logic failSet;    // enable dropped inside a write byte
    logic readOn;     // read phase: drive the data line
  } strobe_t;

endpackage

// File: rtl/spSync.sv
module spSync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);

  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[STAGES-1];

endmodule

// File: rtl/spCtrl.sv
module spCtrl
  import serRegPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceActive,
  input  logic              sclkS,
  input  logic [MODE_W-1:0] modeNib,
  output strobe_t           strb
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  portState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkPrev;
  logic             cePrev;
  logic             sclkRise;
  logic             ceRise;
  logic             ceFall;
  logic             unitEnd;

  always_comb begin
    sclkRise = sclkS & ~sclkPrev & ceActive;
    ceRise   = ceActive & ~cePrev;
    ceFall   = ~ceActive & cePrev;
    unitEnd  = sclkRise && (bitCnt == LAST_BIT);

    strb           = '0;
    strb.shiftIn   = sclkRise && (state == ST_HDR || state == ST_WR);
    strb.latchAddr = unitEnd && (state == ST_HDR);
    strb.incAddr   = unitEnd && (state == ST_WR || state == ST_RD);
    strb.wrStrobe  = unitEnd && (state == ST_WR);
    strb.loadRd    = (unitEnd && state == ST_RD) ||
                     (unitEnd && state == ST_HDR && modeNib == CODE_RD);
    strb.shiftRd   = sclkRise && (state == ST_RD) && !unitEnd;
    strb.failSet   = ceFall && (state == ST_WR) && (bitCnt != '0);
    strb.readOn    = (state == ST_RD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      sclkPrev <= 1'b0;
      cePrev   <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      cePrev   <= ceActive;
      if (!ceActive) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else if (ceRise) begin
        state  <= ST_HDR;
        bitCnt <= '0;
      end else if (sclkRise) begin
        bitCnt <= unitEnd ? '0 : bitCnt + 1'b1;
        if (unitEnd && state == ST_HDR) begin
          if (modeNib == CODE_WR)      state <= ST_WR;
          else if (modeNib == CODE_RD) state <= ST_RD;
          else                         state <= ST_SKIP;
        end
      end
    end
  end

endmodule

// File: rtl/spDatapath.sv
module spDatapath
  import serRegPkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              dinS,
  input  logic [WIDTH-1:0]  rdData,
  output logic [MODE_W-1:0] modeNib,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WIDTH-1:0]  wrData,
  output logic              wrEn,
  output logic              dataOut,
  output logic              dataOe
);

  logic [WIDTH-1:0]  shiftIn;
  logic [WIDTH-1:0]  shiftOut;
  logic [ADDR_W-1:0] addr;
  logic [WIDTH-1:0]  nextByte;
  logic [ADDR_W-1:0] hdrAddr;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    nextByte = {dinS, shiftIn[WIDTH-1:1]};
    modeNib  = nextByte[MODE_W-1:0];
    hdrAddr  = nextByte[MODE_W +: ADDR_W];
    if (strb.latchAddr)    nextAddr = hdrAddr;
    else if (strb.incAddr) nextAddr = addr + 1'b1;
    else                   nextAddr = addr;
  end

  assign rdAddr  = nextAddr;
  assign wrAddr  = addr;
  assign wrData  = nextByte;
  assign wrEn    = strb.wrStrobe;
  assign dataOut = shiftOut[0];
  assign dataOe  = strb.readOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn  <= '0;
      shiftOut <= '0;
      addr     <= '0;
    end else begin
      addr <= nextAddr;
      if (strb.shiftIn) shiftIn <= nextByte;
      if (strb.loadRd)       shiftOut <= rdData;
      else if (strb.shiftRd) shiftOut <= shiftOut >> 1;
    end
  end

endmodule

// File: rtl/spRegBank.sv
module spRegBank #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceActive,
  input  logic                    carryPulse,
  input  logic                    failSet,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WIDTH-1:0]        wrData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [WIDTH-1:0]        rdData,
  output logic [WIDTH*DEPTH-1:0]  regsFlat
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int STAT   = DEPTH - 1;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT);
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] CARRY_M = ONE << (WIDTH - 1);
  localparam logic [WIDTH-1:0] TEST_M  = ONE << (WIDTH - 2);
  localparam logic [WIDTH-1:0] RST_M   = ONE << (WIDTH - 3);
  localparam logic [WIDTH-1:0] FAIL_M  = ONE;
  localparam logic [WIDTH-1:0] HOST_M  = ~(CARRY_M | FAIL_M);
  localparam logic [WIDTH-1:0] CEOFF_M = CARRY_M | TEST_M | RST_M;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] statNext;
  logic             hostWr;

  always_comb begin
    hostWr   = wrEn && (wrAddr == STAT_A);
    statNext = mem[STAT];
    if (hostWr) begin
      statNext = (wrData & HOST_M) | (mem[STAT] & ~HOST_M);
      statNext[0] = mem[STAT][0] & wrData[0];
    end
    if (failSet) statNext = statNext | FAIL_M;
    if (carryPulse && ceActive) statNext = statNext | CARRY_M;
    if (!ceActive) statNext = statNext & ~CEOFF_M;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == STAT) mem[i] <= statNext;
        else if (wrEn && wrAddr == ADDR_W'(i)) mem[i] <= wrData;
      end
    end
  end

  assign rdData = mem[rdAddr];

  for (genvar g = 0; g < DEPTH; g++) begin : gFlat
    assign regsFlat[g*WIDTH +: WIDTH] = mem[g];
  end

endmodule

// File: rtl/serRegPort.sv
module serRegPort
  import serRegPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ce0,
  input  logic                   ce1,
  input  logic                   sclk,
  input  logic                   dataIn,
  input  logic                   carryPulse,
  output logic                   dataOut,
  output logic                   dataOe,
  output logic [WIDTH*DEPTH-1:0] regsOut
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PINS   = 4;

  logic [PINS-1:0]   syncV;
  logic              ceActive;
  strobe_t           strb;
  logic [MODE_W-1:0] modeNib;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [WIDTH-1:0]  wrData;
  logic [WIDTH-1:0]  rdData;
  logic              wrEn;

  spSync #(.N(PINS), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dataIn, sclk, ce1, ce0}),
    .syncOut(syncV)
  );

  assign ceActive = syncV[0] & syncV[1];

  spCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .ceActive(ceActive), .sclkS(syncV[2]),
    .modeNib(modeNib), .strb(strb)
  );

  spDatapath #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(syncV[3]), .rdData(rdData),
    .modeNib(modeNib), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData),
    .wrEn(wrEn), .dataOut(dataOut), .dataOe(dataOe)
  );

  spRegBank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uBank (
    .clk(clk), .rstN(rstN), .ceActive(ceActive), .carryPulse(carryPulse),
    .failSet(strb.failSet), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .regsFlat(regsOut)
  );

endmodule

// File: rtl/spChecker.sv
module spChecker #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   ceActive,
  input logic                   carryPulse,
  input logic                   dataOe,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      wrAddr,
  input logic [WIDTH*DEPTH-1:0] regsFlat
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(DEPTH - 1);

  logic [WIDTH-1:0] statusQ;
  assign statusQ = regsFlat[(DEPTH-1)*WIDTH +: WIDTH];

  // R8: enable low releases the data line
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ceActive |=> !dataOe);

  // R8: enable low clears carry-seen, test and reset bits
  assert_ce_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ceActive |=> (statusQ[WIDTH-1 -: 3] == 3'b000));

  // R9: carry pulse during an active enable sets the flag
  assert_carry_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ceActive && carryPulse) |=> statusQ[WIDTH-1]);

  // R7: write-fail only falls after a host write to the status register
  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusQ[0]) |-> $past(wrEn && wrAddr == STAT_A));

  // R11: no write strobe without both enables
  assert_write_active_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ceActive);

endmodule

bind serRegPort spChecker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .ceActive(ceActive), .carryPulse(carryPulse),
  .dataOe(dataOe), .wrEn(wrEn), .wrAddr(wrAddr), .regsFlat(regsOut)
);

// File: tb/sim_serRegPort.sv
`timescale 1ns/1ps
module sim_serRegPort;
  localparam int W = 8;
  localparam int D = 16;
  localparam int NVEC = 6;
  // {address, data}
  localparam logic [11:0] VEC [NVEC] = '{12'h13C, 12'h281, 12'h5FF, 12'h700, 12'hE96, 12'h16A};

  logic clk = 1'b0, rstN = 1'b0, ce0 = 1'b0, ce1 = 1'b0, sclk = 1'b0;
  logic dataIn = 1'b0, carryPulse = 1'b0;
  logic dataOut, dataOe;
  logic [W*D-1:0] regsOut;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [D];

  always #4 clk = ~clk;

  serRegPort #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rstN(rstN), .ce0(ce0), .ce1(ce1), .sclk(sclk), .dataIn(dataIn),
    .carryPulse(carryPulse), .dataOut(dataOut), .dataOe(dataOe), .regsOut(regsOut)
  );

  function automatic logic [7:0] regAt(input int a);
    return regsOut[a*W +: W];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic pulse);
    @(negedge clk); dataIn = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    carryPulse = pulse;
    @(negedge clk); carryPulse = 1'b0;
    @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v, input int pulseAt);
    for (int i = 0; i < 8; i++) sendBit(v[i], i == pulseAt);
  endtask

  task automatic startTxn(input logic [3:0] mode, input logic [3:0] addr, input logic en1);
    @(negedge clk); ce0 = 1'b1; ce1 = en1;
    repeat (6) @(negedge clk);
    sendByte({addr, mode}, -1);
  endtask

  task automatic endTxn();
    @(negedge clk); ce0 = 1'b0; ce1 = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic readByte(output logic [7:0] v, output logic oeAll, input int pulseAt);
    oeAll = 1'b1;
    for (int i = 0; i < 8; i++) begin
      v[i] = dataOut;
      oeAll = oeAll & dataOe;
      sendBit(1'b0, i == pulseAt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    logic [7:0] stat;
    for (int i = 0; i < D; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 regs in reset", {31'd0, regsOut == '0}, 32'd1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 regs after reset", {31'd0, regsOut == '0}, 32'd1);
    chk("R1 dataOe after reset", {31'd0, dataOe}, 32'd0);

    // table of single-byte writes, each read back
    for (int k = 0; k < NVEC; k++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = VEC[k][11:8]; d = VEC[k][7:0];
      startTxn(4'h3, a, 1'b1); sendByte(d, -1); endTxn();
      mdl[a] = d;
      chk("R2 write stored", {24'd0, regAt(a)}, {24'd0, d});
      startTxn(4'hC, a, 1'b1);
      readByte(v, oe, -1);
      endTxn();
      chk("R4 read data", {24'd0, v}, {24'd0, d});
      chk("R4 dataOe while reading", {31'd0, oe}, 32'd1);
      chk("R8 dataOe released", {31'd0, dataOe}, 32'd0);
    end
    chk("R6 no fail on byte boundary", {24'd0, regAt(15)}, 32'd0);

    // burst with increment
    startTxn(4'h3, 4'h8, 1'b1);
    sendByte(8'h11, -1); sendByte(8'h22, -1); sendByte(8'h33, -1);
    endTxn();
    mdl[8] = 8'h11; mdl[9] = 8'h22; mdl[10] = 8'h33;
    chk("R3 burst reg8", {24'd0, regAt(8)}, 32'h11);
    chk("R3 burst reg9", {24'd0, regAt(9)}, 32'h22);
    chk("R3 burst reg10", {24'd0, regAt(10)}, 32'h33);
    startTxn(4'hC, 4'h8, 1'b1);
    for (int i = 8; i < 11; i++) begin
      readByte(v, oe, -1);
      chk("R3 burst read", {24'd0, v}, {24'd0, mdl[i]});
    end
    endTxn();

    // wrap from 15 to 0 on write
    startTxn(4'h3, 4'hF, 1'b1);
    sendByte(8'h1E, -1); sendByte(8'h77, -1);
    endTxn();
    mdl[0] = 8'h77; stat = 8'h1E;
    chk("R3 wrap status", {24'd0, regAt(15)}, {24'd0, stat});
    chk("R3 wrap reg0", {24'd0, regAt(0)}, 32'h77);

    // read 17 bytes from 15, carry arrives mid first byte
    startTxn(4'hC, 4'hF, 1'b1);
    readByte(v, oe, 3);
    chk("R10 snapshot byte", {24'd0, v}, {24'd0, stat});
    for (int i = 0; i < 15; i++) begin
      readByte(v, oe, -1);
      chk("R3 read sweep", {24'd0, v}, {24'd0, mdl[i]});
    end
    readByte(v, oe, -1);
    chk("R9 carry seen after wrap", {24'd0, v}, {24'd0, stat | 8'h80});
    endTxn();
    chk("R8 carry cleared by enable low", {24'd0, regAt(15)}, {24'd0, stat});

    // carry pulse in the same cycle as a status write
    startTxn(4'h3, 4'hF, 1'b1);
    sendByte(8'h60, 7);
    chk("R9 write and carry together", {24'd0, regAt(15)}, 32'hE0);
    endTxn();
    chk("R8 test and reset cleared", {24'd0, regAt(15)}, 32'h00);

    // invalid mode
    startTxn(4'h5, 4'h1, 1'b1);
    sendByte(8'hFF, -1);
    chk("R5 no drive on bad mode", {31'd0, dataOe}, 32'd0);
    endTxn();
    chk("R5 no write on bad mode", {24'd0, regAt(1)}, {24'd0, mdl[1]});

    // one enable low
    startTxn(4'h3, 4'h2, 1'b0);
    sendByte(8'h00, -1);
    endTxn();
    chk("R11 no write with one enable", {24'd0, regAt(2)}, {24'd0, mdl[2]});

    // aborted byte
    startTxn(4'h3, 4'h3, 1'b1);
    sendByte(8'hA5, -1);
    sendBit(1'b1, 1'b0); sendBit(1'b0, 1'b0); sendBit(1'b1, 1'b0);
    endTxn();
    chk("R6 full byte kept", {24'd0, regAt(3)}, 32'hA5);
    chk("R6 partial byte dropped", {24'd0, regAt(4)}, {24'd0, mdl[4]});
    chk("R6 fail flag set", {24'd0, regAt(15)}, 32'h01);

    startTxn(4'h3, 4'hF, 1'b1); sendByte(8'h01, -1); endTxn();
    chk("R7 writing one keeps flag", {24'd0, regAt(15)}, 32'h01);
    startTxn(4'h3, 4'hF, 1'b1); sendByte(8'h00, -1); endTxn();
    chk("R7 writing zero clears flag", {24'd0, regAt(15)}, 32'h00);
    startTxn(4'h3, 4'hF, 1'b1); sendByte(8'h01, -1); endTxn();
    chk("R7 writing one cannot set", {24'd0, regAt(15)}, 32'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule